// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Detector

This block carries the interrupt and wake logic of one general-purpose I/O pin. It watches the filtered pin level and reacts to it according to a trigger-style bit and a two-bit polarity code. Detected events are held in a sticky interrupt-status bit, and a sticky wake-status bit records events that occur while the selected sleep state has its wake enable set. Software clears either bit by writing a one to it.

Detection and reporting are controlled separately. The detect-enable bit decides whether new events are latched. The unmask bit decides whether a latched status reaches the upstream interrupt request. A small output path drives the pad from an output-enable bit and a drive-value bit, and provides a readable pin-status level.

Top module: `gpio_pin_irq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq_sts`, `wake_sts`, `irq_req` and `src_flag` are 0.
- R2: With `trig_level`=0 (edge style), polarity code 2'b01 latches `irq_sts` on a 0→1 change of `pin_in`, and code 2'b00 latches it on a 1→0 change. The bit is visible one clock after the clock edge at which the new level is sampled.
- R3: Polarity code 2'b10 latches on either change of `pin_in`, whatever the value of `trig_level`.
- R4: Polarity code 2'b11 never sets `irq_sts` or `wake_sts`.
- R5: With `trig_level`=1, code 2'b01 treats a high level as active and code 2'b00 treats a low level as active. While the level stays active, `irq_sts` stays 1 even through a clear write. After the level goes inactive, a clear takes effect.
- R6: While `irq_en`=0, no new event sets `irq_sts`, and an already set `irq_sts` is kept.
- R7: `irq_req` is 1 exactly when `irq_sts`=1 and `irq_unmask`=1.
- R8: A cycle with `clr_wr`=1 and `clr_irq`=1 clears `irq_sts` at the next edge. If `clr_wr` or `clr_irq` is 0, the bit is unchanged.
- R9: An event detected in the same cycle as a clear of `irq_sts` wins, so the bit remains 1.
- R10: `wake_sts` sets on a detected event when `sleep_sel` is 1, 2 or 3 and wake enable bit `wake_en[sleep_sel-1]` is 1, independent of `irq_en`. With `sleep_sel`=0 (awake) it never sets. A write with `clr_wr`=1 and `clr_wake`=1 clears it, and an event in the same cycle wins.
- R11: `src_flag` equals `irq_sts` OR `wake_sts`.
- R12: `pad_oe` follows `out_en`, and `pad_out` equals `out_val` when `out_en`=1 and 0 otherwise. `pin_sts` shows `out_val` when `out_en`=1 and `pin_in` otherwise.
- R13: No edge is detected in the first clock after reset, whatever level `pin_in` holds then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Filtered pin level |
| trig_level | input | 1 | 1 level style, 0 edge style |
| act_code | input | 2 | Polarity code: 00 low/falling, 01 high/rising, 10 both edges, 11 reserved |
| irq_en | input | 1 | Detect enable for interrupt status |
| irq_unmask | input | 1 | 1 lets status reach irq_req |
| wake_en | input | 3 | Wake enable per sleep state (bit 0 light idle, bit 1 suspend-to-RAM, bit 2 hibernate/off) |
| sleep_sel | input | 2 | Current state: 0 awake, 1 to 3 selects wake_en bit 0 to 2 |
| clr_wr | input | 1 | Status write strobe |
| clr_irq | input | 1 | Write-one-to-clear data for irq_sts |
| clr_wake | input | 1 | Write-one-to-clear data for wake_sts |
| out_en | input | 1 | Output enable |
| out_val | input | 1 | Output drive value |
| irq_sts | output | 1 | Sticky interrupt status |
| wake_sts | output | 1 | Sticky wake status |
| irq_req | output | 1 | Interrupt request upstream |
| src_flag | output | 1 | Pin flagged as a source |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad drive value |
| pin_sts | output | 1 | Readable pin status |

## Verification
Directed sequences apply single rising and falling transitions under each polarity code. This separates the edge polarities from each other and from the reserved code. Held levels combined with clear writes show that level style differs from edge style. Clears that land together with a fresh edge show the priority of set over clear. The wake path is driven with detect disabled in each sleep state, so that it is seen to be independent of the interrupt path. A long seeded random run then mixes every control input and compares each output, every cycle, against a model built from the requirements.

// File: rtl/gpio_pin_irq_pkg.sv
package gpio_pin_irq_pkg;

  typedef enum logic [1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_code_e;

  localparam int unsigned DEF_SLEEP_STATES = 3;

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_pin_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       trig_level,
  input  logic [1:0] act_code,
  output logic       evt
);

  logic lvl_q, lvl_d;
  logic vld_q, vld_d;
  logic rise, fall;
  pol_code_e pol;

  assign pol = pol_code_e'(act_code);

  always_comb begin
    lvl_d = pin_in;
    vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      vld_q <= vld_d;
    end
  end

  assign rise = vld_q & pin_in & ~lvl_q;
  assign fall = vld_q & ~pin_in & lvl_q;

  always_comb begin
    unique case (pol)
      POL_LOW:  evt = trig_level ? ~pin_in : fall;
      POL_HIGH: evt = trig_level ? pin_in  : rise;
      POL_BOTH: evt = rise | fall;
      default:  evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_sticky_bit.sv
module gpio_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  logic q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/gpio_wake_select.sv
module gpio_wake_select #(
  parameter  int unsigned NUM_SLEEP = 3,
  localparam int unsigned SEL_W     = $clog2(NUM_SLEEP + 1)
) (
  input  logic [NUM_SLEEP-1:0] wake_en,
  input  logic [SEL_W-1:0]     sleep_sel,
  output logic                 armed
);

  logic [NUM_SLEEP-1:0] hit;

  for (genvar i = 0; i < NUM_SLEEP; i++) begin : g_state
    assign hit[i] = wake_en[i] && (sleep_sel == SEL_W'(i + 1));
  end

  assign armed = |hit;

endmodule

// File: rtl/gpio_pad_path.sv
module gpio_pad_path (
  input  logic out_en,
  input  logic out_val,
  input  logic pin_in,
  output logic pad_oe,
  output logic pad_out,
  output logic pin_sts
);

  assign pad_oe  = out_en;
  assign pad_out = out_en & out_val;
  assign pin_sts = out_en ? out_val : pin_in;

endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
  import gpio_pin_irq_pkg::*;
#(
  parameter  int unsigned NUM_SLEEP = DEF_SLEEP_STATES,
  localparam int unsigned SLEEP_W   = $clog2(NUM_SLEEP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_in,
  input  logic                 trig_level,
  input  logic [1:0]           act_code,
  input  logic                 irq_en,
  input  logic                 irq_unmask,
  input  logic [NUM_SLEEP-1:0] wake_en,
  input  logic [SLEEP_W-1:0]   sleep_sel,
  input  logic                 clr_wr,
  input  logic                 clr_irq,
  input  logic                 clr_wake,
  input  logic                 out_en,
  input  logic                 out_val,
  output logic                 irq_sts,
  output logic                 wake_sts,
  output logic                 irq_req,
  output logic                 src_flag,
  output logic                 pad_oe,
  output logic                 pad_out,
  output logic                 pin_sts
);

  logic evt;
  logic wake_armed;
  logic irq_set, irq_clr;
  logic wake_set, wake_clr;

  gpio_evt_detect u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .trig_level (trig_level),
    .act_code   (act_code),
    .evt        (evt)
  );

  gpio_wake_select #(.NUM_SLEEP(NUM_SLEEP)) u_wsel (
    .wake_en   (wake_en),
    .sleep_sel (sleep_sel),
    .armed     (wake_armed)
  );

  assign irq_set  = evt & irq_en;
  assign irq_clr  = clr_wr & clr_irq;
  assign wake_set = evt & wake_armed;
  assign wake_clr = clr_wr & clr_wake;

  gpio_sticky_bit u_irq_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .q     (irq_sts)
  );

  gpio_sticky_bit u_wake_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wake_set),
    .clr_i (wake_clr),
    .q     (wake_sts)
  );

  assign irq_req  = irq_sts & irq_unmask;
  assign src_flag = irq_sts | wake_sts;

  gpio_pad_path u_pad (
    .out_en  (out_en),
    .out_val (out_val),
    .pin_in  (pin_in),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pin_sts (pin_sts)
  );

endmodule

// File: rtl/gpio_pin_irq_checker.sv
module gpio_pin_irq_checker #(
  parameter  int unsigned NUM_SLEEP = 3,
  localparam int unsigned SLEEP_W   = $clog2(NUM_SLEEP + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pin_in,
  input logic                 trig_level,
  input logic [1:0]           act_code,
  input logic                 irq_en,
  input logic                 irq_unmask,
  input logic [SLEEP_W-1:0]   sleep_sel,
  input logic                 clr_wr,
  input logic                 clr_irq,
  input logic                 out_en,
  input logic                 out_val,
  input logic                 irq_sts,
  input logic                 wake_sts,
  input logic                 irq_req,
  input logic                 pad_out
);

  a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == 2'b11 && !irq_sts && !(clr_wr && clr_irq)) |=> !irq_sts);

  a_r6_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !irq_sts) |=> !irq_sts);

  a_r7_req_needs_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_sts && irq_unmask));

  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_irq && !irq_en) |=> !irq_sts);

  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_level && irq_en && act_code == 2'b01 && pin_in) |=> irq_sts);

  a_r10_awake_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_sel == '0 && !wake_sts) |=> !wake_sts);

  a_r12_pad_value: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (pad_out == out_val));

endmodule

bind gpio_pin_irq gpio_pin_irq_checker #(.NUM_SLEEP(NUM_SLEEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_in     (pin_in),
  .trig_level (trig_level),
  .act_code   (act_code),
  .irq_en     (irq_en),
  .irq_unmask (irq_unmask),
  .sleep_sel  (sleep_sel),
  .clr_wr     (clr_wr),
  .clr_irq    (clr_irq),
  .out_en     (out_en),
  .out_val    (out_val),
  .irq_sts    (irq_sts),
  .wake_sts   (wake_sts),
  .irq_req    (irq_req),
  .pad_out    (pad_out)
);

// File: tb/gpio_pin_irq_test.sv
module gpio_pin_irq_test;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic pin_in, trig_level, irq_en, irq_unmask, clr_wr, clr_irq, clr_wake, out_en, out_val;
  logic [1:0] act_code, sleep_sel;
  logic [2:0] wake_en;
  logic irq_sts, wake_sts, irq_req, src_flag, pad_oe, pad_out, pin_sts;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic m_prev, m_vld, m_irq, m_wake;

  always #(CLK_P/2) clk = ~clk;

  gpio_pin_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .trig_level(trig_level),
    .act_code(act_code), .irq_en(irq_en), .irq_unmask(irq_unmask),
    .wake_en(wake_en), .sleep_sel(sleep_sel), .clr_wr(clr_wr),
    .clr_irq(clr_irq), .clr_wake(clr_wake), .out_en(out_en), .out_val(out_val),
    .irq_sts(irq_sts), .wake_sts(wake_sts), .irq_req(irq_req),
    .src_flag(src_flag), .pad_oe(pad_oe), .pad_out(pad_out), .pin_sts(pin_sts)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model_evt(logic pin, logic prev, logic vld, logic lvl, logic [1:0] code);
    logic r, f;
    r = vld & pin & ~prev;
    f = vld & ~pin & prev;
    case (code)
      2'b00:   return lvl ? ~pin : f;
      2'b01:   return lvl ? pin : r;
      2'b10:   return r | f;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic model_armed(logic [2:0] en, logic [1:0] sel);
    return (sel != 2'd0) && en[sel - 2'd1];
  endfunction

  task automatic step();
    logic e;
    e = model_evt(pin_in, m_prev, m_vld, trig_level, act_code);
    @(posedge clk);
    #1;
    if (clr_wr && clr_irq)  m_irq  = 1'b0;
    if (e && irq_en)        m_irq  = 1'b1;
    if (clr_wr && clr_wake) m_wake = 1'b0;
    if (e && model_armed(wake_en, sleep_sel)) m_wake = 1'b1;
    m_prev = pin_in;
    m_vld  = 1'b1;
    check("R2 irq_sts vs model", irq_sts, m_irq);
    check("R10 wake_sts vs model", wake_sts, m_wake);
    check("R7 irq_req", irq_req, m_irq & irq_unmask);
    check("R11 src_flag", src_flag, m_irq | m_wake);
    check("R12 pad_oe", pad_oe, out_en);
    check("R12 pad_out", pad_out, out_en & out_val);
    check("R12 pin_sts", pin_sts, out_en ? out_val : pin_in);
  endtask

  task automatic quiet();
    clr_wr = 0; clr_irq = 0; clr_wake = 0;
  endtask

  task automatic clear_all();
    clr_wr = 1; clr_irq = 1; clr_wake = 1;
    step();
    quiet();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7717));
    rst_n = 0;
    pin_in = 1; trig_level = 0; act_code = 2'b01; irq_en = 1; irq_unmask = 1;
    wake_en = 3'b111; sleep_sel = 2'd1; out_en = 0; out_val = 0;
    quiet();
    m_prev = 0; m_vld = 0; m_irq = 0; m_wake = 0;
    #(CLK_P * 3 + 2);
    check("R1 irq_sts in reset", irq_sts, 1'b0);
    check("R1 wake_sts in reset", wake_sts, 1'b0);
    check("R1 irq_req in reset", irq_req, 1'b0);
    check("R1 src_flag in reset", src_flag, 1'b0);
    rst_n = 1;
    step();
    check("R13 no edge right after reset", irq_sts, 1'b0);
    check("R1 wake clear first cycle", wake_sts, 1'b0);
    step();
    check("R13 held level no edge", irq_sts, 1'b0);

    // R2 rising, code 01
    sleep_sel = 2'd0;
    pin_in = 0; step();
    check("R2 falling ignored by code 01", irq_sts, 1'b0);
    pin_in = 1; step();
    check("R2 rising latched", irq_sts, 1'b1);
    check("R7 req when unmasked", irq_req, 1'b1);
    irq_unmask = 0; step();
    check("R7 req masked", irq_req, 1'b0);
    check("R7 status kept while masked", irq_sts, 1'b1);
    irq_unmask = 1;
    clr_wr = 1; clr_irq = 0; step();
    check("R8 write of zero keeps status", irq_sts, 1'b1);
    clr_wr = 0; clr_irq = 1; step();
    check("R8 no strobe keeps status", irq_sts, 1'b1);
    clr_wr = 1; step(); quiet();
    check("R8 clear", irq_sts, 1'b0);

    // R2 falling, code 00
    act_code = 2'b00;
    pin_in = 0; step();
    check("R2 falling latched code 00", irq_sts, 1'b1);
    clear_all();
    pin_in = 1; step();
    check("R2 rising ignored code 00", irq_sts, 1'b0);

    // R4 reserved
    act_code = 2'b11;
    pin_in = 0; step(); pin_in = 1; step();
    trig_level = 1; step();
    check("R4 reserved never sets", irq_sts, 1'b0);
    trig_level = 0;

    // R3 both edges
    act_code = 2'b10;
    pin_in = 0; step();
    check("R3 falling with both", irq_sts, 1'b1);
    clear_all();
    pin_in = 1; step();
    check("R3 rising with both", irq_sts, 1'b1);
    clear_all();
    trig_level = 1; step();
    check("R3 no edge no set in level style", irq_sts, 1'b0);
    pin_in = 0; step();
    check("R3 edge in level style", irq_sts, 1'b1);
    clear_all();

    // R5 level style
    act_code = 2'b01; trig_level = 1;
    pin_in = 1; step();
    check("R5 high level sets", irq_sts, 1'b1);
    clr_wr = 1; clr_irq = 1; step(); quiet();
    check("R5 clear ignored while active", irq_sts, 1'b1);
    pin_in = 0; step();
    check("R5 stays after inactive", irq_sts, 1'b1);
    clear_all();
    check("R5 clear after inactive", irq_sts, 1'b0);
    act_code = 2'b00; step();
    check("R5 low level active code 00", irq_sts, 1'b1);
    pin_in = 1; clear_all();
    trig_level = 0;

    // R6 detect disabled
    irq_en = 0; act_code = 2'b01;
    pin_in = 0; step(); pin_in = 1; step();
    check("R6 no set when disabled", irq_sts, 1'b0);
    irq_en = 1; pin_in = 0; step(); pin_in = 1; step();
    irq_en = 0; step();
    check("R6 kept when disabled", irq_sts, 1'b1);
    irq_en = 1;

    // R9 set beats clear
    pin_in = 0; step();
    pin_in = 1; clr_wr = 1; clr_irq = 1; step(); quiet();
    check("R9 edge wins over clear", irq_sts, 1'b1);
    clear_all();

    // R10 wake
    irq_en = 0; sleep_sel = 2'd2; wake_en = 3'b010;
    pin_in = 0; step(); pin_in = 1; step();
    check("R10 wake set in state 2", wake_sts, 1'b1);
    check("R10 irq untouched", irq_sts, 1'b0);
    check("R11 src from wake", src_flag, 1'b1);
    pin_in = 0; step();
    pin_in = 1; clr_wr = 1; clr_wake = 1; step(); quiet();
    check("R10 event wins over wake clear", wake_sts, 1'b1);
    clear_all();
    check("R10 wake cleared", wake_sts, 1'b0);
    sleep_sel = 2'd3; pin_in = 0; step(); pin_in = 1; step();
    check("R10 state 3 not enabled", wake_sts, 1'b0);
    sleep_sel = 2'd0; wake_en = 3'b111; pin_in = 0; step(); pin_in = 1; step();
    check("R10 awake never wakes", wake_sts, 1'b0);
    irq_en = 1;

    // R12 pad
    out_en = 1; out_val = 1; pin_in = 0; step();
    check("R12 pad drives value", pad_out, 1'b1);
    check("R12 pin_sts shows drive", pin_sts, 1'b1);
    out_en = 0; step();
    check("R12 pad off", pad_out, 1'b0);
    check("R12 pin_sts shows input", pin_sts, 1'b0);

    // random
    for (int i = 0; i < 4000; i++) begin
      pin_in     = ($urandom % 3) == 0 ? ~pin_in : pin_in;
      if (($urandom % 16) == 0) trig_level = $urandom;
      if (($urandom % 16) == 0) act_code   = $urandom;
      if (($urandom % 8)  == 0) irq_en     = $urandom;
      if (($urandom % 8)  == 0) irq_unmask = $urandom;
      if (($urandom % 16) == 0) wake_en    = $urandom;
      if (($urandom % 16) == 0) sleep_sel  = $urandom;
      clr_wr   = ($urandom % 5) == 0;
      clr_irq  = $urandom;
      clr_wake = $urandom;
      out_en   = $urandom;
      out_val  = $urandom;
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule